// File: doc/BRIEF.md
# Key-Armed Watchdog with Reset Pulse

This block is a watchdog for a small controller that sits on a byte-wide register bus. Software arms it by writing a two-byte key to one register address. Once the key has been written, a counter advances once per machine cycle. Each machine cycle is six or twelve oscillator clocks, depending on a mode input. Software must write the same key again before the counter runs out. That key write clears the counter and restarts the machine-cycle divider.

If software misses the deadline, the block drives a reset output high. The pulse has a fixed length in oscillator clocks, and that length depends on the clock mode. When the pulse ends, the watchdog returns to its power-on state: disarmed, counter cleared and key tracker empty. There is no register write that turns the watchdog off. Only a hardware reset or its own overflow pulse disarms it. The key register cannot be read, and the counter is not visible to software.

Top module: `wdg_guard`

## Requirements
- R1: After reset, `rst_pulse` is low and the watchdog is disarmed; without a completed key it never pulses, however long the clock runs.
- R2: Writing 0x1E and then 0xE1 as two consecutive writes to address 0xA6 arms the watchdog. The write of 0xE1 happens on clock edge k. The counter (2^CNT_W-1 = 16383 machine cycles at the default width) then runs out, and `rst_pulse` rises after edge k + (2^CNT_W-1)*D, where D is 6 when `mode_sel`=0 and 12 when `mode_sel`=1.
- R3: A write of 0xE1 to 0xA6 completes the key only if the previous write to 0xA6 was 0x1E. Any other value written to 0xA6 discards a half-entered key.
- R4: Writes to any address other than 0xA6 have no effect, and they do not discard a half-entered key.
- R5: Once armed, no sequence of register writes disarms the watchdog. Partial or wrong keys do not stop the pulse, and they do not delay it.
- R6: A complete key written while armed clears the counter and the divider, so the next pulse moves to (2^CNT_W-1)*D clocks after that key's 0xE1 edge. A key whose 0xE1 lands on the very edge of the final machine-cycle tick takes priority and prevents the pulse.
- R7: `rst_pulse` stays high for exactly PULSE_6 (98) clocks when `mode_sel`=0 and for exactly PULSE_12 (196) clocks when `mode_sel`=1.
- R8: After the pulse ends, the block is back in its power-on state. It does not pulse again unless it is re-armed by a full key, and re-arming works the same way as the first time.
- R9: Holding `rst_n` low on a clock edge disarms the watchdog and cancels any pending or active pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| mode_sel | input | 1 | 0: six clocks per machine cycle; 1: twelve clocks per machine cycle |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Write data byte |
| rst_pulse | output | 1 | Watchdog reset output, high during the overflow pulse |

## Verification
The checker examines four things on every cycle. The output must stay low for the cycle after a reset. A rising pulse must always follow a complete key seen at the ports since the last reset or pulse. The pulse must never rise in the cycle right after a key completes. Every pulse must last exactly the length set by the mode.

The exact timing depends on how machine-cycle ticks line up with key writes, and only the bench's scenarios show it. Those scenarios cover the overflow position after arming and after servicing, and a service landing on the final tick. They also cover half-entered keys that are broken or survive foreign writes, attempts to disarm the watchdog, and re-arming after a pulse. The reduced counter width used by the bench keeps these windows short.

// File: rtl/wdg_pkg.sv
// Package: shared constants and types for the key-armed watchdog.
// Assumes an 8-bit register address and data bus.
package wdg_pkg;
    localparam logic [7:0] KEY_ADDR   = 8'hA6;
    localparam logic [7:0] KEY_FIRST  = 8'h1E;
    localparam logic [7:0] KEY_SECOND = 8'hE1;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_PRIMED
    } seq_t;
endpackage

// File: rtl/wdg_prescale.sv
// Machine-cycle divider: produces a one-clock tick every DIV_LO or DIV_HI
// clocks while running. Assumes mode_sel is static while running; restart
// puts the phase back to zero so the first tick is a full period later.
module wdg_prescale #(
    parameter int DIV_LO = 6,
    parameter int DIV_HI = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic mode_sel,
    output logic tick
);
    localparam int PSW = $clog2(DIV_HI);
    localparam logic [PSW-1:0] LAST_LO = PSW'(DIV_LO - 1);
    localparam logic [PSW-1:0] LAST_HI = PSW'(DIV_HI - 1);

    logic [PSW-1:0] phase;
    logic [PSW-1:0] last;

    // Pick the terminal phase for the selected clock mode.
    always_comb last = mode_sel ? LAST_HI : LAST_LO;

    assign tick = run && (phase == last);

    // Advance the phase, wrapping at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) phase <= '0;
        else if (phase == last)         phase <= '0;
        else                            phase <= phase + 1'b1;
    end
endmodule

// File: rtl/wdg_keyseq.sv
// Key tracker: watches bus writes to the key address and flags a completed
// two-byte key. Writes elsewhere are ignored; blocked writes are ignored.
module wdg_keyseq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wipe,
    input  logic       block,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       key_done
);
    import wdg_pkg::*;

    seq_t state;
    logic hit;

    // A write that reaches the key register.
    assign hit      = wr_en && !block && (wr_addr == KEY_ADDR);
    assign key_done = hit && (state == SEQ_PRIMED) && (wr_data == KEY_SECOND);

    // Track whether the last key-register write was the first key byte.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe)               state <= SEQ_IDLE;
        else if (hit && wr_data == KEY_FIRST) state <= SEQ_PRIMED;
        else if (hit)                     state <= SEQ_IDLE;
    end
endmodule

// File: rtl/wdg_pulse.sv
// Reset pulse generator: once started, holds active for PULSE_6 or PULSE_12
// clocks and flags done in its final cycle. Assumes mode_sel is static.
module wdg_pulse #(
    parameter int PULSE_6  = 98,
    parameter int PULSE_12 = 196
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mode_sel,
    output logic active,
    output logic done
);
    localparam int PMAX = (PULSE_12 > PULSE_6) ? PULSE_12 : PULSE_6;
    localparam int PLW  = $clog2(PMAX);
    localparam logic [PLW-1:0] END_6  = PLW'(PULSE_6 - 1);
    localparam logic [PLW-1:0] END_12 = PLW'(PULSE_12 - 1);

    logic [PLW-1:0] pcnt;

    assign done = active && (pcnt == (mode_sel ? END_12 : END_6));

    // Hold the pulse and count its length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            pcnt   <= '0;
        end else if (done) begin
            active <= 1'b0;
            pcnt   <= '0;
        end else if (active) begin
            pcnt   <= pcnt + 1'b1;
        end else if (start) begin
            active <= 1'b1;
            pcnt   <= '0;
        end
    end
endmodule

// File: rtl/wdg_guard.sv
// Key-armed watchdog top: arms on a two-byte key, counts machine cycles and
// emits a fixed-length reset pulse on overflow. Assumes a synchronous
// active-low reset and a mode_sel that only changes while disarmed.
module wdg_guard #(
    parameter int CNT_W    = 14,
    parameter int DIV_LO   = 6,
    parameter int DIV_HI   = 12,
    parameter int PULSE_6  = 98,
    parameter int PULSE_12 = 196
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_sel,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       rst_pulse
);
    localparam logic [CNT_W-1:0] CNT_LAST = {{(CNT_W-1){1'b1}}, 1'b0};

    logic             armed;
    logic [CNT_W-1:0] count;
    logic             tick;
    logic             key_done;
    logic             pulse_on;
    logic             wipe;
    logic             expire;

    // The final tick overflows unless a key lands on the same edge.
    assign expire    = tick && (count == CNT_LAST) && !key_done;
    assign rst_pulse = pulse_on;

    wdg_keyseq u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe     (wipe),
        .block    (pulse_on),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .key_done (key_done)
    );

    wdg_prescale #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (armed && !pulse_on),
        .restart  (key_done || wipe),
        .mode_sel (mode_sel),
        .tick     (tick)
    );

    wdg_pulse #(.PULSE_6(PULSE_6), .PULSE_12(PULSE_12)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (expire),
        .mode_sel (mode_sel),
        .active   (pulse_on),
        .done     (wipe)
    );

    // One-time arm flag: set by a key, cleared only by reset or pulse end.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) armed <= 1'b0;
        else if (key_done)  armed <= 1'b1;
    end

    // Machine-cycle counter: cleared by key, advanced by tick, held at overflow.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe || key_done) count <= '0;
        else if (tick && !expire)       count <= count + 1'b1;
    end
endmodule

// File: rtl/wdg_guard_chk.sv
// Checker for wdg_guard: observes ports only and tracks keys and pulse
// length independently. Assumes mode_sel is static during a pulse.
module wdg_guard_chk #(
    parameter int PULSE_6  = 98,
    parameter int PULSE_12 = 196
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_sel,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       rst_pulse
);
    logic        half_q;
    logic        key_seen;
    logic        key_now;
    logic [15:0] hi_run;
    logic [15:0] want_len;

    assign key_now  = wr_en && wr_addr == 8'hA6 && wr_data == 8'hE1 && half_q;
    assign want_len = mode_sel ? 16'(PULSE_12) : 16'(PULSE_6);

    // Follow key bytes and remember a completed key since the last pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q   <= 1'b0;
            key_seen <= 1'b0;
        end else begin
            if (wr_en && wr_addr == 8'hA6) half_q <= (wr_data == 8'h1E);
            if (key_now) key_seen <= 1'b1;
            else if (!rst_pulse && hi_run != 16'd0) key_seen <= 1'b0;
        end
    end

    // Count consecutive high cycles of the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)         hi_run <= '0;
        else if (rst_pulse) hi_run <= hi_run + 16'd1;
        else                hi_run <= '0;
    end

    // R9
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !rst_pulse);

    // R1
    needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pulse) |-> key_seen);

    // R6
    service_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pulse) |-> !$past(key_now));

    // R7
    pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> hi_run < want_len);

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pulse) |-> hi_run == want_len);
endmodule

bind wdg_guard wdg_guard_chk #(.PULSE_6(PULSE_6), .PULSE_12(PULSE_12)) u_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rst_pulse (rst_pulse)
);

// File: tb/test_wdg_guard.sv
// Scoreboard bench for wdg_guard: driver tasks queue expected pulses
// (rise cycle, length); a monitor pops and compares them at negedges.
module test_wdg_guard;
    localparam int CW   = 5;
    localparam int MAXC = (1 << CW) - 1;

    typedef struct {
        int rise;
        int len;
    } pulse_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       rst_pulse;

    int     cyc = 0;
    int     checks = 0;
    int     fails = 0;
    int     rises = 0;
    int     rise_at = 0;
    logic   prev = 1'b0;
    pulse_t expq[$];
    pulse_t cur;
    bit     done = 0;

    wdg_guard #(.CNT_W(CW)) i_wdg_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rst_pulse (rst_pulse)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Monitor: compare observed pulses against the expectation queue.
    always @(negedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else begin
            if (rst_pulse && !prev) begin
                rises++;
                rise_at = cyc;
                if (expq.size() == 0) begin
                    check(0, "R1/R5 unexpected pulse", cyc, -1);
                    cur.len = -1;
                end else begin
                    cur = expq.pop_front();
                    check(cyc == cur.rise, "R2/R6 pulse rise cycle", cyc, cur.rise);
                end
            end
            if (!rst_pulse && prev && cur.len >= 0)
                check(cyc - rise_at == cur.len, "R7 pulse length", cyc - rise_at, cur.len);
            prev <= rst_pulse;
        end
    end

    // Single bus write; call at a negedge, returns the sampling edge number.
    task automatic wr(input logic [7:0] a, input logic [7:0] d, output int edge_n);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        edge_n = cyc;
    endtask

    task automatic key(output int edge_n);
        int e;
        wr(8'hA6, 8'h1E, e);
        wr(8'hA6, 8'hE1, edge_n);
    endtask

    function automatic int window();
        return MAXC * (mode_sel ? 12 : 6);
    endfunction

    task automatic expect_pulse(input int k);
        pulse_t p;
        p.rise = k + window();
        p.len  = mode_sel ? 196 : 98;
        expq.push_back(p);
    endtask

    task automatic quiet(input int n, input string tag);
        int r0 = rises;
        repeat (n) @(negedge clk);
        check(rises == r0 && rst_pulse == 1'b0, tag, rises - r0, 0);
    endtask

    task automatic drain(input string tag);
        repeat (window() + 220) @(negedge clk);
        check(expq.size() == 0, tag, expq.size(), 0);
    endtask

    initial begin
        int k;
        int e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rst_pulse == 1'b0, "R1 reset value", rst_pulse, 0);
        quiet(500, "R1 no pulse while disarmed");

        // R3: lone second byte, and a broken key
        wr(8'hA6, 8'hE1, e);
        quiet(300, "R3 lone 0xE1 does not arm");
        wr(8'hA6, 8'h1E, e);
        wr(8'hA6, 8'h55, e);
        wr(8'hA6, 8'hE1, e);
        quiet(300, "R3 other value breaks key");

        // R4 + R2 + R7 in six-clock mode: foreign writes between key bytes
        wr(8'hA6, 8'h1E, e);
        wr(8'hA5, 8'h00, e);
        wr(8'h00, 8'hE1, e);
        wr(8'hA6, 8'hE1, k);
        expect_pulse(k);
        drain("R4 R2 pulse after arming (6-clock)");
        quiet(400, "R8 no pulse after return to power-on");

        // R5 in twelve-clock mode: disarm attempts do not stop or delay
        mode_sel = 1'b1;
        @(negedge clk);
        key(k);
        expect_pulse(k);
        repeat (50) @(negedge clk);
        wr(8'hA6, 8'h00, e);
        wr(8'hA6, 8'hE1, e);
        wr(8'hA6, 8'h1E, e);
        wr(8'hA6, 8'hFF, e);
        drain("R5 still pulses, R7 twelve-clock length");

        // R8 re-arm and R6 periodic service, then service on the final tick
        key(k);
        for (int i = 0; i < 3; i++) begin
            repeat (300) @(negedge clk);
            key(k);
        end
        while (cyc < k + window() - 2) @(negedge clk);
        key(e);
        check(e == k + window(), "R6 service on final tick edge", e, k + window());
        expect_pulse(e);
        drain("R6 R8 pulse after last service");

        // R9: reset while armed cancels the pending pulse
        mode_sel = 1'b0;
        @(negedge clk);
        key(k);
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        quiet(400, "R9 reset disarms");

        check(expq.size() == 0, "R2 all expected pulses seen", expq.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog for a hung run.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule